// File: doc/BRIEF.md
# Ingress Replay-Protection Association Tracker

This block keeps the per-flow state that a secured-link receiver needs after decryption. It holds a bank of receive channels and a bank of receive associations. Every decrypted frame arrives as a one-cycle strobe with a channel index, an association index, a 32-bit packet number and a flag saying whether its integrity check passed. The block judges the frame against the association's expected next packet number, using the channel's replay window and validation policy. It returns an accept or drop decision with a late-frame flag one cycle later, and it updates the stored state in the same edge.

Software programs and inspects every row through a single-word table port. The read side is combinational. A write takes effect at the next clock edge. Hardware owns the expected packet number after programming, along with the saturation, in-use and fresh bits. Each channel's receiving bit is derived continuously from its associations.

Top module: `rx_replay_tracker`

## Requirements
- R1: `dec_vld` is high for exactly the cycle after a cycle with `frm_vld` high, and carries that frame's decision. After reset all outputs are 0, and every row reads back as all zeros.
- R2: a frame whose channel row or association row has its valid bit clear is dropped with `dec_late`=0, and it changes no stored state.
- R3: with replay protection on, a frame is late when its packet number is below (expected − window), with the difference floored at 0. A window of 0 therefore demands pn ≥ expected. With replay protection off, no frame is late.
- R4: policy code 0 (strict) accepts a frame only when it is not late and its integrity check passed. Code 3 behaves as strict.
- R5: policy code 1 (check) drops late frames. It accepts a frame that failed its integrity check and raises `dec_unverified` with it.
- R6: policy code 2 (disabled) accepts every frame on valid rows. `dec_late` is still reported, and `dec_unverified` marks a failed integrity check.
- R7: an accepted frame sets the expected number to max(expected, pn+1). A dropped frame leaves it unchanged.
- R8: when the accepted frame has pn = 0xFFFF_FFFF, the expected number becomes 0 and the saturation bit (assoc word bit 32) is set. The saturation bit stays set until software rewrites the row.
- R9: an accepted frame sets the association's in-use bit (bit 33) and clears the association's fresh bit (bit 34) and the channel's fresh bit (channel word bit 35).
- R10: channel word bit 37 (receiving) reads 1 exactly when some association whose owner field (assoc word bits 40:36) equals that channel has its in-use bit set.
- R11: a frame in the cycle right after another frame on the same association is judged against the state that the first frame left behind.
- R12: table port. `tbl_sel`=0 addresses channels and `tbl_sel`=1 addresses associations. Channel word: window 31:0, policy 33:32, replay enable 34, fresh 35, valid 36. Association word: expected 31:0, sat 32, in-use 33, fresh 34, valid 35, owner 40:36. The receiving bit ignores writes. A software write wins over a same-cycle hardware update of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_vld | input | 1 | Frame strobe |
| frm_ch | input | 5 | Channel index of the frame |
| frm_as | input | 5 | Association index of the frame |
| frm_pn | input | 32 | Packet number of the frame |
| frm_icv_ok | input | 1 | Integrity check passed |
| dec_vld | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_late | output | 1 | Frame fell below the replay window |
| dec_unverified | output | 1 | Accepted although the integrity check failed |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | 0 selects channel rows, 1 selects association rows |
| tbl_idx | input | 5 | Row index for read and write |
| tbl_wdata | input | 41 | Row write word |
| tbl_rdata | output | 41 | Row read word (combinational) |

## Verification
The bench targets the window edge. A packet number exactly at expected−window must pass and one below it must fail. An off-by-one in the subtraction or the comparison would flip those two outcomes. A window larger than the expected number probes the floor at 0; an unfloored design would wrap around and call every frame late. Back-to-back duplicates on one association catch a design that reads stale state and accepts a replay. The all-ones packet number catches a missing saturation bit or an expected number stuck at the old value. A same-cycle software write and accepted frame on one row catches the wrong priority. Finally, a write to the receiving bit must not stick.

// File: rtl/rxr_pkg.sv
// Shared types of the replay-protection tracker.
// Assumes 32-bit packet numbers and a two-bit validation policy code.
package rxr_pkg;
    localparam int PN_W = 32;

    typedef enum logic [1:0] {
        VM_STRICT = 2'd0,
        VM_CHECK  = 2'd1,
        VM_OFF    = 2'd2,
        VM_RSVD   = 2'd3
    } vmode_e;

    // Channel row, packed MSB first: valid, fresh, replay_en, vmode, window.
    typedef struct packed {
        logic            valid;
        logic            fresh;
        logic            replay_en;
        vmode_e          vmode;
        logic [PN_W-1:0] window;
    } ch_row_t;

    // Association row without the owner field: valid, fresh, in_use, sat, next_pn.
    typedef struct packed {
        logic            valid;
        logic            fresh;
        logic            in_use;
        logic            sat;
        logic [PN_W-1:0] next_pn;
    } as_core_t;
endpackage

// File: rtl/rxr_chan_bank.sv
// Channel row storage held in flops, so every row is visible at once.
// Assumes a software write and a hardware use of the same row may coincide;
// the software write wins.
module rxr_chan_bank
    import rxr_pkg::*;
#(
    parameter  int NUM_CH = 32,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [CH_W-1:0] sw_idx,
    input  ch_row_t         sw_row,
    input  logic            use_en,
    input  logic [CH_W-1:0] use_idx,
    output ch_row_t         rows [NUM_CH]
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_row
        // Row update: reset, software load, or fresh clear on first use.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[i] <= '0;
            end else if (sw_we && sw_idx == CH_W'(i)) begin
                rows[i] <= sw_row;
            end else if (use_en && use_idx == CH_W'(i)) begin
                rows[i].fresh <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxr_assoc_bank.sv
// Association row storage with hardware update of the packet number state.
// Assumes the update values are already resolved by the decision logic;
// a same-cycle software write to the row takes priority.
module rxr_assoc_bank
    import rxr_pkg::*;
#(
    parameter  int NUM_AS = 32,
    parameter  int CH_W   = 5,
    localparam int AS_W   = $clog2(NUM_AS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [AS_W-1:0] sw_idx,
    input  as_core_t        sw_core,
    input  logic [CH_W-1:0] sw_owner,
    input  logic            upd_en,
    input  logic [AS_W-1:0] upd_idx,
    input  logic [PN_W-1:0] upd_next,
    input  logic            upd_sat,
    output as_core_t        rows  [NUM_AS],
    output logic [CH_W-1:0] owner [NUM_AS]
);
    for (genvar i = 0; i < NUM_AS; i++) begin : g_row
        // Row update: reset, software load, or accepted-frame bookkeeping.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[i]  <= '0;
                owner[i] <= '0;
            end else if (sw_we && sw_idx == AS_W'(i)) begin
                rows[i]  <= sw_core;
                owner[i] <= sw_owner;
            end else if (upd_en && upd_idx == AS_W'(i)) begin
                rows[i].next_pn <= upd_next;
                rows[i].sat     <= upd_sat;
                rows[i].in_use  <= 1'b1;
                rows[i].fresh   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxr_judge.sv
// Combinational frame judgement: late test, policy, and next expected number.
// Assumes the selected channel and association rows are already muxed in.
module rxr_judge
    import rxr_pkg::*;
(
    input  ch_row_t         ch,
    input  as_core_t        as_r,
    input  logic [PN_W-1:0] pn,
    input  logic            icv_ok,
    output logic            accept,
    output logic            late,
    output logic            unverified,
    output logic [PN_W-1:0] next_pn,
    output logic            sat
);
    logic [PN_W-1:0] floor_pn;
    logic [PN_W:0]   bumped;
    logic            usable;

    // Decision and successor state for one frame.
    always_comb begin
        floor_pn = (ch.window >= as_r.next_pn) ? '0 : as_r.next_pn - ch.window;
        usable   = ch.valid && as_r.valid;
        late     = usable && ch.replay_en && (pn < floor_pn);
        case (ch.vmode)
            VM_OFF:   accept = usable;
            VM_CHECK: accept = usable && !late;
            default:  accept = usable && !late && icv_ok;
        endcase
        unverified = accept && !icv_ok;
        bumped     = {1'b0, pn} + (PN_W+1)'(1);
        if (bumped > {1'b0, as_r.next_pn}) begin
            next_pn = bumped[PN_W-1:0];
            sat     = as_r.sat | bumped[PN_W];
        end else begin
            next_pn = as_r.next_pn;
            sat     = as_r.sat;
        end
    end
endmodule

// File: rtl/rx_replay_tracker.sv
// Top of the replay-protection tracker: row banks, frame judgement,
// registered decision outputs and the software table port.
// Assumes tbl_idx stays below the row count of the selected bank.
module rx_replay_tracker
    import rxr_pkg::*;
#(
    parameter  int NUM_CH = 32,
    parameter  int NUM_AS = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int AS_W   = $clog2(NUM_AS),
    localparam int IDX_W  = (CH_W > AS_W) ? CH_W : AS_W,
    localparam int TBL_W  = PN_W + 4 + CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_vld,
    input  logic [CH_W-1:0]  frm_ch,
    input  logic [AS_W-1:0]  frm_as,
    input  logic [PN_W-1:0]  frm_pn,
    input  logic             frm_icv_ok,
    output logic             dec_vld,
    output logic             dec_accept,
    output logic             dec_late,
    output logic             dec_unverified,
    input  logic             tbl_we,
    input  logic             tbl_sel,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [TBL_W-1:0] tbl_wdata,
    output logic [TBL_W-1:0] tbl_rdata
);
    ch_row_t         ch_rows  [NUM_CH];
    as_core_t        as_rows  [NUM_AS];
    logic [CH_W-1:0] as_owner [NUM_AS];
    logic [NUM_CH-1:0] recv;
    ch_row_t         sel_ch;
    as_core_t        sel_as;
    logic            j_accept, j_late, j_unv, j_sat;
    logic [PN_W-1:0] j_next;
    logic            take;
    logic [1:0]      sel_mode_w;
    logic            sel_usable_w;

    assign sel_ch       = ch_rows[frm_ch];
    assign sel_as       = as_rows[frm_as];
    assign take         = frm_vld && j_accept;
    assign sel_mode_w   = sel_ch.vmode;
    assign sel_usable_w = sel_ch.valid && sel_as.valid;

    rxr_chan_bank #(.NUM_CH(NUM_CH)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (tbl_we && !tbl_sel),
        .sw_idx  (tbl_idx[CH_W-1:0]),
        .sw_row  (ch_row_t'(tbl_wdata[PN_W+4:0])),
        .use_en  (take),
        .use_idx (frm_ch),
        .rows    (ch_rows)
    );

    rxr_assoc_bank #(.NUM_AS(NUM_AS), .CH_W(CH_W)) u_assoc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (tbl_we && tbl_sel),
        .sw_idx   (tbl_idx[AS_W-1:0]),
        .sw_core  (as_core_t'(tbl_wdata[PN_W+3:0])),
        .sw_owner (tbl_wdata[TBL_W-1:PN_W+4]),
        .upd_en   (take),
        .upd_idx  (frm_as),
        .upd_next (j_next),
        .upd_sat  (j_sat),
        .rows     (as_rows),
        .owner    (as_owner)
    );

    rxr_judge u_judge (
        .ch         (sel_ch),
        .as_r       (sel_as),
        .pn         (frm_pn),
        .icv_ok     (frm_icv_ok),
        .accept     (j_accept),
        .late       (j_late),
        .unverified (j_unv),
        .next_pn    (j_next),
        .sat        (j_sat)
    );

    // Receiving bit per channel: OR of in-use over the associations it owns.
    always_comb begin
        recv = '0;
        for (int a = 0; a < NUM_AS; a++) begin
            if (as_rows[a].in_use) recv[as_owner[a]] = 1'b1;
        end
    end

    // Decision register: one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld        <= 1'b0;
            dec_accept     <= 1'b0;
            dec_late       <= 1'b0;
            dec_unverified <= 1'b0;
        end else begin
            dec_vld        <= frm_vld;
            dec_accept     <= frm_vld && j_accept;
            dec_late       <= frm_vld && j_late;
            dec_unverified <= frm_vld && j_unv;
        end
    end

    // Table read mux: channel word with derived receiving bit, or association word.
    always_comb begin
        if (tbl_sel) begin
            tbl_rdata = {as_owner[tbl_idx[AS_W-1:0]], as_rows[tbl_idx[AS_W-1:0]]};
        end else begin
            tbl_rdata = TBL_W'({recv[tbl_idx[CH_W-1:0]], ch_rows[tbl_idx[CH_W-1:0]]});
        end
    end
endmodule

// File: rtl/rx_replay_tracker_chk.sv
// Property checker for the replay tracker, attached to the top by bind.
// Assumes it sees the frame inputs and the selected-row summary from the top.
module rx_replay_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_vld,
    input logic       frm_icv_ok,
    input logic [1:0] sel_mode,
    input logic       sel_usable,
    input logic       dec_vld,
    input logic       dec_accept,
    input logic       dec_late,
    input logic       dec_unverified
);
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> dec_vld);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> !dec_vld && !dec_accept && !dec_late);
    p_invalid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld && !sel_usable |=> !dec_accept && !dec_late);
    p_strict_icv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld && sel_mode == 2'd0 && !frm_icv_ok |=> !dec_accept);
    p_check_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld && sel_mode == 2'd1 |=> !(dec_late && dec_accept));
    p_unverified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_unverified |-> dec_accept);
    p_disabled_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld && sel_mode == 2'd2 && sel_usable |=> dec_accept);
endmodule

bind rx_replay_tracker rx_replay_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frm_vld        (frm_vld),
    .frm_icv_ok     (frm_icv_ok),
    .sel_mode       (sel_mode_w),
    .sel_usable     (sel_usable_w),
    .dec_vld        (dec_vld),
    .dec_accept     (dec_accept),
    .dec_late       (dec_late),
    .dec_unverified (dec_unverified)
);

// File: tb/rx_replay_tracker_tb_top.sv
module rx_replay_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int NAS = 32;
    localparam int TW  = 41;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_vld = 1'b0;
    logic [4:0]    frm_ch = '0;
    logic [4:0]    frm_as = '0;
    logic [31:0]   frm_pn = '0;
    logic          frm_icv_ok = 1'b0;
    logic          dec_vld, dec_accept, dec_late, dec_unverified;
    logic          tbl_we = 1'b0;
    logic          tbl_sel = 1'b0;
    logic [4:0]    tbl_idx = '0;
    logic [TW-1:0] tbl_wdata = '0;
    logic [TW-1:0] tbl_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_replay_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_ch(frm_ch), .frm_as(frm_as),
        .frm_pn(frm_pn), .frm_icv_ok(frm_icv_ok), .dec_vld(dec_vld), .dec_accept(dec_accept),
        .dec_late(dec_late), .dec_unverified(dec_unverified), .tbl_we(tbl_we),
        .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    // Behavioural reference state
    longint m_win [NCH];
    int     m_mode[NCH];
    bit     m_ren [NCH], m_cfr[NCH], m_cv[NCH];
    longint m_next[NAS];
    bit     m_sat [NAS], m_use[NAS], m_afr[NAS], m_av[NAS];
    int     m_own [NAS];
    bit     e_vld, e_acc, e_late, e_unv;
    string  e_req;
    string  cur_req = "R1";
    int     checks = 0;
    int     fails  = 0;
    bit     done   = 0;

    // Reference model: evaluated at each rising edge from the stable inputs.
    always @(posedge clk) begin : model
        int c, a;
        bit lt, acc;
        longint lo, nx;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_win[i] = 0; m_mode[i] = 0; m_ren[i] = 0; m_cfr[i] = 0; m_cv[i] = 0;
            end
            for (int i = 0; i < NAS; i++) begin
                m_next[i] = 0; m_sat[i] = 0; m_use[i] = 0; m_afr[i] = 0; m_av[i] = 0; m_own[i] = 0;
            end
            e_vld = 0; e_acc = 0; e_late = 0; e_unv = 0; e_req = "R1";
        end else begin
            e_vld = frm_vld; e_acc = 0; e_late = 0; e_unv = 0; e_req = cur_req;
            if (frm_vld) begin
                c = int'(frm_ch);
                a = int'(frm_as);
                if (m_cv[c] && m_av[a]) begin
                    lo  = m_next[a] - m_win[c];
                    lt  = m_ren[c] && (longint'(frm_pn) < lo);
                    if (m_mode[c] == 2)      acc = 1;
                    else if (m_mode[c] == 1) acc = !lt;
                    else                     acc = !lt && frm_icv_ok;
                    e_late = lt; e_acc = acc; e_unv = acc && !frm_icv_ok;
                    if (acc) begin
                        nx = longint'(frm_pn) + 1;
                        if (nx > m_next[a]) m_next[a] = nx;
                        if (m_next[a] == (64'd1 << 32)) begin
                            m_next[a] = 0;
                            m_sat[a]  = 1;
                        end
                        m_use[a] = 1; m_afr[a] = 0; m_cfr[c] = 0;
                    end
                end
            end
            if (tbl_we) begin
                if (!tbl_sel) begin
                    m_win[tbl_idx]  = longint'(tbl_wdata[31:0]);
                    m_mode[tbl_idx] = int'(tbl_wdata[33:32]);
                    m_ren[tbl_idx]  = tbl_wdata[34];
                    m_cfr[tbl_idx]  = tbl_wdata[35];
                    m_cv[tbl_idx]   = tbl_wdata[36];
                end else begin
                    m_next[tbl_idx] = longint'(tbl_wdata[31:0]);
                    m_sat[tbl_idx]  = tbl_wdata[32];
                    m_use[tbl_idx]  = tbl_wdata[33];
                    m_afr[tbl_idx]  = tbl_wdata[34];
                    m_av[tbl_idx]   = tbl_wdata[35];
                    m_own[tbl_idx]  = int'(tbl_wdata[40:36]);
                end
            end
        end
    end

    // Per-clock comparison of the decision outputs against the model.
    always begin
        @(posedge clk);
        #2;
        if (!done) begin
            checks++;
            if ({dec_vld, dec_accept, dec_late, dec_unverified} !== {e_vld, e_acc, e_late, e_unv}) begin
                fails++;
                $display("FAIL %s decision t=%0t actual vld/acc/late/unv=%b%b%b%b expected=%b%b%b%b",
                         e_req, $time, dec_vld, dec_accept, dec_late, dec_unverified,
                         e_vld, e_acc, e_late, e_unv);
            end
        end
    end

    function automatic logic [TW-1:0] ch_word(input int c);
        logic [TW-1:0] w;
        bit r;
        r = 0;
        for (int a = 0; a < NAS; a++) if (m_use[a] && m_own[a] == c) r = 1;
        w = '0;
        w[31:0] = m_win[c][31:0]; w[33:32] = 2'(m_mode[c]); w[34] = m_ren[c];
        w[35] = m_cfr[c]; w[36] = m_cv[c]; w[37] = r;
        return w;
    endfunction

    function automatic logic [TW-1:0] as_word(input int a);
        logic [TW-1:0] w;
        w = '0;
        w[31:0] = m_next[a][31:0]; w[32] = m_sat[a]; w[33] = m_use[a];
        w[34] = m_afr[a]; w[35] = m_av[a]; w[40:36] = 5'(m_own[a]);
        return w;
    endfunction

    task automatic rd_chk(input bit sel, input int idx, input string req);
        logic [TW-1:0] exp;
        @(negedge clk);
        tbl_sel = sel; tbl_idx = 5'(idx);
        #1;
        exp = sel ? as_word(idx) : ch_word(idx);
        checks++;
        if (tbl_rdata !== exp) begin
            fails++;
            $display("FAIL %s readback sel=%0d idx=%0d actual=%h expected=%h", req, sel, idx, tbl_rdata, exp);
        end
    endtask

    task automatic val_chk(input logic [TW-1:0] act, input logic [TW-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s value actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ch(input int idx, input bit v, input bit f, input bit ren,
                         input int mode, input logic [31:0] win, input bit rbit);
        @(negedge clk);
        tbl_we = 1; tbl_sel = 0; tbl_idx = 5'(idx);
        tbl_wdata = '0;
        tbl_wdata[31:0] = win; tbl_wdata[33:32] = 2'(mode); tbl_wdata[34] = ren;
        tbl_wdata[35] = f; tbl_wdata[36] = v; tbl_wdata[37] = rbit;
        @(negedge clk);
        tbl_we = 0;
    endtask

    function automatic logic [TW-1:0] mk_as(input int own, input bit v, input bit f,
                                            input bit u, input bit s, input logic [31:0] pn);
        return {5'(own), v, f, u, s, pn};
    endfunction

    task automatic wr_as(input int idx, input logic [TW-1:0] w);
        @(negedge clk);
        tbl_we = 1; tbl_sel = 1; tbl_idx = 5'(idx); tbl_wdata = w;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic frame(input int c, input int a, input logic [31:0] pn, input bit ok, input string req);
        @(negedge clk);
        frm_vld = 1; frm_ch = 5'(c); frm_as = 5'(a); frm_pn = pn; frm_icv_ok = ok; cur_req = req;
        @(negedge clk);
        frm_vld = 0; cur_req = "R1";
    endtask

    // Two frames on consecutive cycles, same association.
    task automatic frame2(input int c, input int a, input logic [31:0] pn0,
                          input logic [31:0] pn1, input string req);
        @(negedge clk);
        frm_vld = 1; frm_ch = 5'(c); frm_as = 5'(a); frm_pn = pn0; frm_icv_ok = 1; cur_req = req;
        @(negedge clk);
        frm_pn = pn1;
        @(negedge clk);
        frm_vld = 0; cur_req = "R1";
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(0, 3, "R1");
        rd_chk(1, 7, "R1");
        val_chk(tbl_rdata, '0, "R1");

        // Strict channel 3, window 0; association 7 expects 100
        wr_ch(3, 1, 1, 1, 0, 32'd0, 0);
        wr_as(7, mk_as(3, 1, 1, 0, 0, 32'd100));
        rd_chk(1, 7, "R12");
        rd_chk(0, 3, "R10");
        frame(3, 7, 32'd100, 1, "R4");
        rd_chk(1, 7, "R7");
        val_chk(tbl_rdata, mk_as(3, 1, 0, 1, 0, 32'd101), "R9");
        rd_chk(0, 3, "R10");
        val_chk(tbl_rdata[37:35], 3'b110, "R10");
        frame(3, 7, 32'd100, 1, "R3");
        frame(3, 7, 32'd101, 1, "R3");
        frame(3, 7, 32'd200, 0, "R4");
        rd_chk(1, 7, "R7");
        val_chk(tbl_rdata[31:0], 32'd102, "R7");
        // R11 duplicate back-to-back
        frame2(3, 7, 32'd150, 32'd150, "R11");
        frame2(3, 7, 32'd160, 32'd161, "R11");
        rd_chk(1, 7, "R11");

        // Check-mode channel 4, window 10; association 8 expects 1000
        wr_ch(4, 1, 1, 1, 1, 32'd10, 0);
        wr_as(8, mk_as(4, 1, 1, 0, 0, 32'd1000));
        frame(4, 8, 32'd990, 1, "R3");
        frame(4, 8, 32'd989, 1, "R5");
        rd_chk(1, 8, "R7");
        val_chk(tbl_rdata[31:0], 32'd1000, "R7");
        frame(4, 8, 32'd1005, 0, "R5");
        rd_chk(1, 8, "R5");

        // Window larger than expected: floor at 0
        wr_ch(9, 1, 1, 1, 0, 32'd5000, 0);
        wr_as(14, mk_as(9, 1, 1, 0, 0, 32'd20));
        frame(9, 14, 32'd0, 1, "R3");

        // Disabled policy channel 5, association 9 expects 50
        wr_ch(5, 1, 1, 1, 2, 32'd0, 0);
        wr_as(9, mk_as(5, 1, 1, 0, 0, 32'd50));
        frame(5, 9, 32'd10, 0, "R6");
        rd_chk(1, 9, "R6");
        // Reserved policy 3 behaves as strict
        wr_ch(8, 1, 1, 1, 3, 32'd0, 0);
        wr_as(15, mk_as(8, 1, 1, 0, 0, 32'd5));
        frame(8, 15, 32'd9, 0, "R4");

        // Replay off channel 6
        wr_ch(6, 1, 1, 0, 0, 32'd0, 0);
        wr_as(10, mk_as(6, 1, 1, 0, 0, 32'd500));
        frame(6, 10, 32'd5, 1, "R3");
        rd_chk(1, 10, "R7");

        // Invalid rows
        wr_as(11, mk_as(3, 0, 1, 0, 0, 32'd40));
        frame(3, 11, 32'd60, 1, "R2");
        rd_chk(1, 11, "R2");
        wr_as(12, mk_as(7, 1, 1, 0, 0, 32'd40));
        frame(7, 12, 32'd60, 1, "R2");
        rd_chk(1, 12, "R2");
        rd_chk(0, 7, "R2");

        // Saturation
        wr_as(13, mk_as(3, 1, 1, 0, 0, 32'hFFFF_FFF0));
        frame(3, 13, 32'hFFFF_FFFF, 1, "R8");
        rd_chk(1, 13, "R8");
        val_chk(tbl_rdata, mk_as(3, 1, 0, 1, 1, 32'd0), "R8");
        frame(3, 13, 32'd3, 1, "R8");
        rd_chk(1, 13, "R8");

        // Software write collides with an accepted frame on the same row
        @(negedge clk);
        frm_vld = 1; frm_ch = 5'd3; frm_as = 5'd7; frm_pn = 32'd900; frm_icv_ok = 1; cur_req = "R12";
        tbl_we = 1; tbl_sel = 1; tbl_idx = 5'd7; tbl_wdata = mk_as(3, 1, 1, 0, 0, 32'd7);
        @(negedge clk);
        frm_vld = 0; tbl_we = 0; cur_req = "R1";
        rd_chk(1, 7, "R12");
        val_chk(tbl_rdata, mk_as(3, 1, 1, 0, 0, 32'd7), "R12");

        // Receiving bit ignores writes
        wr_ch(20, 1, 0, 0, 0, 32'd0, 1);
        rd_chk(0, 20, "R12");
        val_chk(tbl_rdata[37], 1'b0, "R10");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule